// File: doc/BRIEF.md
# Disable-Tone Status and Bypass Controller

This block keeps, for each channel of a multi-channel echo canceller, a sticky flag that records whether a network disable tone has been heard. Every channel has two tone-recognition inputs, one watching the receive path and one watching the send path, and four level flags. Each flag reports that one path carries energy above its limit in one of two bands: the low band (390–700 Hz, limit -30 dBm0) and the high band (700–3400 Hz, limit -34 dBm0). The tone recognition and the level estimation are done upstream. This block only sees their one-bit results, together with a 1 ms tick.

A hit from either recogniser sets the channel's flag. The flag then holds without any further tone. It drops only after both paths have stayed under both band limits for an uninterrupted hold time, 400 ticks by default. Every rise and every fall of the flag marks the channel as having an unserviced event, and the shared active-low interrupt stays asserted while any channel has one. A per-channel selection picks which tone standard the recognisers should look for. The channel's adaptation/bypass state can be run in one of two ways. In automatic mode the flag itself drives the state. Otherwise an external controller, having polled the flags after the interrupt, writes the state through the register port.

Top module: `tone_bypass_ctrl`

## Requirements
- R1: After reset, all status, pending and bypass bits are 0, the standard and automatic selections are 0, and `irq_n` is 1.
- R2: A 1 on `rx_tone[c]` or `tx_tone[c]` in a cycle sets status bit c from the next clock edge.
- R3: Once set, a status bit stays 1 with no tone present for as long as any of the channel's four level flags is 1.
- R4: A set status bit clears on the edge that accepts the HOLD_MS-th `ms_tick` of an unbroken quiet run, where all four level flags are 0 and no tone is present. Any level flag or tone at 1 restarts the run from zero.
- R5: Every rise or fall of status bit c sets pending bit c. Writing 1 to bit c at address 1 clears it, and an edge in the same cycle takes priority. `irq_n` is 0 exactly while any pending bit is 1.
- R6: Address 2 holds one standard-select bit per channel (1 = G.164, 0 = G.165). The register drives `std_sel_o` and reads back unchanged.
- R7: While automatic bit c (address 3) is 1, `bypass_o[c]` equals the status bit of the previous cycle, so it enters bypass one cycle after the set and leaves one cycle after the release. Writes to address 4 have no effect on that bit.
- R8: While automatic bit c is 0, `bypass_o[c]` changes only through a write to address 4 and ignores status changes.
- R9: Reads of address 0 return the status bits, 1 the pending bits, and 4 the bypass bits. Addresses 5 to 7 read 0, and writes to address 0 or to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| rx_tone | input | N_CH | Receive-path disable tone recognised, per channel |
| tx_tone | input | N_CH | Send-path disable tone recognised, per channel |
| rx_loud_lo | input | N_CH | Receive path above limit in the low band |
| rx_loud_hi | input | N_CH | Receive path above limit in the high band |
| tx_loud_lo | input | N_CH | Send path above limit in the low band |
| tx_loud_hi | input | N_CH | Send path above limit in the high band |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | N_CH | Write data, one bit per channel |
| reg_rdata | output | N_CH | Read data for `reg_addr` (combinational) |
| std_sel_o | output | N_CH | Tone standard selection to the recognisers |
| bypass_o | output | N_CH | Bypass state per channel (1 = bypass) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The first set of directed patterns checks the hold timer. Quiet runs of 399 and then 400 ticks separate a correct count from an off-by-one. A single loud cycle in the middle of a run separates a counter that restarts from one that merely pauses. Level flags held high for longer than the hold time confirm the stickiness. Other directed patterns set one channel from each path, and they compare an automatic channel with a manual one under the same tone, which separates status-driven bypass from write-driven bypass. Constrained-random traffic then alternates noisy and quiet phases with sparse tones and random register writes, including clears that collide with edges, and every output and the read port are compared each cycle against a reference model built from the requirements.

// File: rtl/tbc_pkg.sv
// Shared definitions for the disable-tone status controller.
// Assumes a three-bit register address space; data width equals channel count.
package tbc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_STATUS = 3'd0,
        A_PEND   = 3'd1,
        A_STD    = 3'd2,
        A_AUTO   = 3'd3,
        A_BYP    = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/tbc_chan.sv
// One channel: sticky tone status, quiet-interval counter, pending event
// flag and bypass state. Assumes ms_tick is a single-cycle pulse and that
// the level flags are already synchronous to clk.
module tbc_chan #(
    parameter int HOLD_MS = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic rx_hit,
    input  logic tx_hit,
    input  logic rx_lo,
    input  logic rx_hi,
    input  logic tx_lo,
    input  logic tx_hi,
    input  logic auto_en,
    input  logic pend_clr,
    input  logic byp_we,
    input  logic byp_wd,
    output logic status_o,
    output logic pend_o,
    output logic bypass_o
);
    localparam int CNT_W = (HOLD_MS > 2) ? $clog2(HOLD_MS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_MS - 1);

    logic             stat_q, stat_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pend_q, byp_q;
    logic             hit, quiet;

    assign hit   = rx_hit | tx_hit;
    assign quiet = ~(rx_lo | rx_hi | tx_lo | tx_hi);

    // Next status and quiet-run count: tone sets, noise restarts, full run releases.
    always_comb begin
        stat_d = stat_q;
        cnt_d  = cnt_q;
        if (hit) begin
            stat_d = 1'b1;
            cnt_d  = '0;
        end else if (!stat_q || !quiet) begin
            cnt_d = '0;
        end else if (ms_tick) begin
            if (cnt_q == LAST) begin
                stat_d = 1'b0;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // State registers for status and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            stat_q <= stat_d;
            cnt_q  <= cnt_d;
        end
    end

    // Pending flag: set on either status edge, else cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (stat_d != stat_q) pend_q <= 1'b1;
        else if (pend_clr)         pend_q <= 1'b0;
    end

    // Bypass: follows status in automatic mode, else only register writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       byp_q <= 1'b0;
        else if (auto_en) byp_q <= stat_q;
        else if (byp_we)  byp_q <= byp_wd;
    end

    assign status_o = stat_q;
    assign pend_o   = pend_q;
    assign bypass_o = byp_q;

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !(quiet && ms_tick)) |=> stat_q);
    a_r4_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q) |-> ($past(cnt_q) == LAST && $past(quiet) && $past(ms_tick)));
    a_r4_noise_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (!quiet) |=> (cnt_q == '0));
    a_r2_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> stat_q);
    a_r5_edge_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q != $past(stat_q)) |-> pend_q);
    a_r7_auto_track: assert property (@(posedge clk) disable iff (!rst_n)
        auto_en |=> (byp_q == $past(stat_q)));
    a_r8_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !byp_we) |=> $stable(byp_q));
endmodule

// File: rtl/tbc_regfile.sv
// Control registers (standard select, automatic mode), write decode into
// per-channel strobes, and the read multiplexer. Assumes single-cycle
// writes and a combinational read path.
module tbc_regfile
    import tbc_pkg::*;
#(
    parameter int N_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N_CH-1:0]   reg_wdata,
    input  logic [N_CH-1:0]   status_i,
    input  logic [N_CH-1:0]   pend_i,
    input  logic [N_CH-1:0]   bypass_i,
    output logic [N_CH-1:0]   reg_rdata,
    output logic [N_CH-1:0]   std_sel,
    output logic [N_CH-1:0]   auto_en,
    output logic [N_CH-1:0]   pend_clr,
    output logic              byp_we
);
    logic [N_CH-1:0] std_q, auto_q;

    // Writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_q  <= '0;
            auto_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == A_STD)  std_q  <= reg_wdata;
            if (reg_addr == A_AUTO) auto_q <= reg_wdata;
        end
    end

    assign pend_clr = (reg_we && reg_addr == A_PEND) ? reg_wdata : '0;
    assign byp_we   = reg_we && (reg_addr == A_BYP);
    assign std_sel  = std_q;
    assign auto_en  = auto_q;

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        case (reg_addr)
            A_STATUS: reg_rdata = status_i;
            A_PEND:   reg_rdata = pend_i;
            A_STD:    reg_rdata = std_q;
            A_AUTO:   reg_rdata = auto_q;
            A_BYP:    reg_rdata = bypass_i;
            default:  reg_rdata = '0;
        endcase
    end

    a_r6_std_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_STD) |=> (std_q == $past(reg_wdata)));
    a_r6_std_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == A_STD) |=> $stable(std_q));
endmodule

// File: rtl/tone_bypass_ctrl.sv
// Top level: one tbc_chan per channel, a shared register file, and the
// active-low interrupt that is asserted while any channel has a pending event.
// Assumes all inputs are synchronous to clk.
module tone_bypass_ctrl
    import tbc_pkg::*;
#(
    parameter int N_CH    = 32,
    parameter int HOLD_MS = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic [N_CH-1:0]   rx_tone,
    input  logic [N_CH-1:0]   tx_tone,
    input  logic [N_CH-1:0]   rx_loud_lo,
    input  logic [N_CH-1:0]   rx_loud_hi,
    input  logic [N_CH-1:0]   tx_loud_lo,
    input  logic [N_CH-1:0]   tx_loud_hi,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N_CH-1:0]   reg_wdata,
    output logic [N_CH-1:0]   reg_rdata,
    output logic [N_CH-1:0]   std_sel_o,
    output logic [N_CH-1:0]   bypass_o,
    output logic              irq_n
);
    logic [N_CH-1:0] status, pend, auto_en, pend_clr;
    logic            byp_we;

    tbc_regfile #(.N_CH(N_CH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .status_i (status),
        .pend_i   (pend),
        .bypass_i (bypass_o),
        .reg_rdata(reg_rdata),
        .std_sel  (std_sel_o),
        .auto_en  (auto_en),
        .pend_clr (pend_clr),
        .byp_we   (byp_we)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        tbc_chan #(.HOLD_MS(HOLD_MS)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ms_tick (ms_tick),
            .rx_hit  (rx_tone[c]),
            .tx_hit  (tx_tone[c]),
            .rx_lo   (rx_loud_lo[c]),
            .rx_hi   (rx_loud_hi[c]),
            .tx_lo   (tx_loud_lo[c]),
            .tx_hi   (tx_loud_hi[c]),
            .auto_en (auto_en[c]),
            .pend_clr(pend_clr[c]),
            .byp_we  (byp_we),
            .byp_wd  (reg_wdata[c]),
            .status_o(status[c]),
            .pend_o  (pend[c]),
            .bypass_o(bypass_o[c])
        );
    end

    assign irq_n = ~|pend;

    a_r5_irq_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (status != $past(status)) |-> !irq_n);
endmodule

// File: tb/tone_bypass_ctrl_bench.sv
module tone_bypass_ctrl_bench;
    localparam int N    = 32;
    localparam int HOLD = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic [N-1:0] rx_tone = '0, tx_tone = '0;
    logic [N-1:0] rl = '0, rh = '0, tl = '0, th = '0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata, std_sel_o, bypass_o;
    logic irq_n;

    int checks = 0, fails = 0;

    bit [N-1:0] m_stat, m_pend, m_byp, m_std, m_auto;
    int m_cnt [N];

    tone_bypass_ctrl u_tone_bypass_ctrl (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .rx_tone(rx_tone), .tx_tone(tx_tone),
        .rx_loud_lo(rl), .rx_loud_hi(rh), .tx_loud_lo(tl), .tx_loud_hi(th),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .std_sel_o(std_sel_o), .bypass_o(bypass_o),
        .irq_n(irq_n)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [N-1:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return m_stat;
            3'd1: return m_pend;
            3'd2: return m_std;
            3'd3: return m_auto;
            3'd4: return m_byp;
            default: return '0;
        endcase
    endfunction

    // Reference model for one clock edge, from the requirements.
    task automatic model_step();
        bit [N-1:0] ns = m_stat, np = m_pend, nb = m_byp;
        for (int c = 0; c < N; c++) begin
            bit hit = rx_tone[c] | tx_tone[c];
            bit quiet = !(rl[c] | rh[c] | tl[c] | th[c]);
            if (hit) begin ns[c] = 1; m_cnt[c] = 0; end
            else if (!m_stat[c] || !quiet) m_cnt[c] = 0;
            else if (ms_tick) begin
                if (m_cnt[c] == HOLD - 1) begin ns[c] = 0; m_cnt[c] = 0; end
                else m_cnt[c]++;
            end
            if (ns[c] != m_stat[c]) np[c] = 1;
            else if (reg_we && reg_addr == 3'd1 && reg_wdata[c]) np[c] = 0;
            if (m_auto[c]) nb[c] = m_stat[c];
            else if (reg_we && reg_addr == 3'd4) nb[c] = reg_wdata[c];
        end
        if (reg_we && reg_addr == 3'd2) m_std = reg_wdata;
        if (reg_we && reg_addr == 3'd3) m_auto = reg_wdata;
        m_stat = ns; m_pend = np; m_byp = nb;
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk); #1;
        chk("R7/R8 bypass", bypass_o, m_byp);
        chk("R6 std_sel", std_sel_o, m_std);
        chk("R5 irq_n", {{(N-1){1'b0}}, irq_n}, {{(N-1){1'b0}}, ~|m_pend});
        chk("R9 rdata", reg_rdata, exp_rd(reg_addr));
    endtask

    task automatic idle();
        rx_tone = '0; tx_tone = '0; reg_we = 0; ms_tick = 0;
    endtask

    task automatic wr(logic [2:0] a, logic [N-1:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d; cycle(); reg_we = 0;
    endtask

    task automatic peek(logic [2:0] a, string req, logic [N-1:0] exp);
        reg_addr = a; #1; chk(req, reg_rdata, exp);
    endtask

    task automatic ticks(int n);
        ms_tick = 1; repeat (n) cycle(); ms_tick = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed_0043));
        for (int c = 0; c < N; c++) m_cnt[c] = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        peek(3'd0, "R1 status", '0); peek(3'd1, "R1 pend", '0);
        peek(3'd4, "R1 bypass", '0); peek(3'd3, "R1 auto", '0);
        chk("R1 irq_n", {31'b0, irq_n}, 32'd1);
        chk("R1 std", std_sel_o, '0);
        // R2 set from receive path on ch0, send path on ch5
        rx_tone[0] = 1; cycle(); idle();
        peek(3'd0, "R2 rx set", 32'h1);
        chk("R5 irq on set", {31'b0, irq_n}, 32'd0);
        tx_tone[5] = 1; cycle(); idle();
        peek(3'd0, "R2 tx set", 32'h21);
        wr(3'd1, 32'h21);
        chk("R5 w1c clears irq", {31'b0, irq_n}, 32'd1);
        // R3 sticky under noise for longer than the hold time
        rh[0] = 1; ticks(HOLD + 200);
        peek(3'd0, "R3 sticky", 32'h1);
        rh[0] = 0;
        // R4 off-by-one and restart
        ticks(HOLD - 1);
        peek(3'd0, "R4 399 ticks hold", 32'h1);
        tl[0] = 1; cycle(); tl[0] = 0;
        ticks(HOLD - 1);
        peek(3'd0, "R4 restart holds", 32'h1);
        ticks(1);
        peek(3'd0, "R4 released", 32'h0);
        peek(3'd1, "R5 release pends", 32'h21);
        wr(3'd1, '1);
        // R6 standard select
        wr(3'd2, 32'hA5A5_0F0F);
        chk("R6 std out", std_sel_o, 32'hA5A5_0F0F);
        // R7 automatic on ch3, R8 manual on ch7
        wr(3'd3, 32'h8);
        rx_tone[3] = 1; rx_tone[7] = 1; cycle(); idle();
        chk("R7 not yet bypass", bypass_o, 32'h0);
        cycle();
        chk("R7 bypass after set", bypass_o, 32'h8);
        wr(3'd4, 32'h0);
        chk("R7 write ignored", bypass_o, 32'h8);
        wr(3'd4, 32'h80);
        chk("R8 manual write", bypass_o, 32'h88);
        // R9 unmapped/readonly writes
        wr(3'd0, '0); wr(3'd6, '1);
        peek(3'd0, "R9 status unchanged", 32'h88);
        peek(3'd6, "R9 unmapped reads 0", '0);
        // R7 release path for ch3
        ticks(HOLD);
        peek(3'd0, "R4 both released", 32'h0);
        cycle();
        chk("R7 bypass leaves", bypass_o, 32'h80);
        // constrained random phases
        for (int ph = 0; ph < 10; ph++) begin
            bit noisy = ph[0];
            for (int k = 0; k < 600; k++) begin
                for (int c = 0; c < N; c++) begin
                    rx_tone[c] = ($urandom_range(0, 299) == 0);
                    tx_tone[c] = ($urandom_range(0, 299) == 0);
                    rl[c] = noisy && ($urandom_range(0, 3) == 0);
                    rh[c] = noisy && ($urandom_range(0, 3) == 0);
                    tl[c] = noisy && ($urandom_range(0, 3) == 0);
                    th[c] = noisy && ($urandom_range(0, 3) == 0);
                end
                ms_tick = 1'b1;
                reg_we = ($urandom_range(0, 19) == 0);
                reg_addr = 3'($urandom_range(0, 7));
                reg_wdata = $urandom;
                cycle();
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule